// File: doc/BRIEF.md
# Full-Duplex Framed SPI Slave Port

This block is a slave-only SPI port that moves length-prefixed link frames in both directions at the same time. The host supplies SCK and the active-low select NSS, drives MOSI, and reads MISO. The block only ever drives MISO. Two static strap inputs select the idle level of the shift clock and the edge on which bits are sampled. All SPI inputs are brought into the local clock domain through a synchronizer, so SCK must be several times slower than `clk`.

On the receive side, zero bytes count as idle filler. The first non-zero byte is taken as a frame length. The block then collects exactly that many further bytes, hands each one out with a strobe, and ends the frame with a one-cycle completion pulse that carries the byte count. This work is done by the receive state machine, which has two states. In RX_HUNT it waits for a non-zero byte (transition HUNT_TO_BODY). In RX_BODY it counts body bytes down and returns to RX_HUNT after the last one (transition BODY_TO_HUNT).

On the transmit side, local logic presents an outbound frame byte by byte, with the length byte first, using `tx_valid`, `tx_data` and `tx_last`. The transmit state machine leaves TX_IDLE for TX_PEND as soon as a byte is offered (transition IDLE_TO_PEND) and raises `host_irq` while in TX_PEND. It returns to TX_IDLE once the byte marked last has been completely shifted out (transition PEND_TO_IDLE). Each fully shifted byte is acknowledged with `tx_ack`. A byte cut short by NSS is not acknowledged and goes out again in the next transfer. When nothing is offered, MISO carries zeros.

Top module: `spi_frame_port`

## Requirements
- R1: After reset, `spi_miso`, `host_irq`, `rx_data_valid`, `frame_valid` and `tx_ack` are all 0.
- R2: When no outbound byte is offered, every byte the host reads on MISO is 0x00.
- R3: Bits move most significant bit first in both directions. A byte is complete after eight sampling edges while NSS is low.
- R4: With `strap_cpol`=0 the clock idles low, and with `strap_cpol`=1 it idles high. With `strap_cpha`=0 the slave samples MOSI on the first edge of each bit and the host must find bit 7 on MISO before that edge. With `strap_cpha`=1 the slave samples on the second edge and updates MISO on the first. All four combinations carry data correctly.
- R5: While hunting, a received 0x00 byte is ignored. A non-zero byte N is taken as the length. The next N bytes each appear on `rx_data` with `rx_data_valid`, and together with the Nth byte `frame_valid` pulses with `frame_bytes`=N.
- R6: Raising NSS clears the bit counter and discards a partially received byte. The next transfer starts on a byte boundary.
- R7: `host_irq` rises after an outbound byte is offered and stays high across NSS windows until the byte flagged `tx_last` has been fully shifted out. It then falls.
- R8: Outbound bytes leave in the order offered. `tx_ack` pulses once per byte fully shifted out. A byte interrupted by NSS is not acknowledged and is sent again from bit 7.
- R9: A frame received on MOSI and a frame sent on MISO during the same transfer do not affect each other.
- R10: While NSS is high, `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, oversamples SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_cpol | input | 1 | Static strap: SCK idle level |
| strap_cpha | input | 1 | Static strap: 0 samples on first edge, 1 on second |
| spi_sck | input | 1 | Host shift clock |
| spi_nss | input | 1 | Host select, active low |
| spi_mosi | input | 1 | Data from host |
| spi_miso | output | 1 | Data to host |
| tx_valid | input | 1 | An outbound byte is offered |
| tx_data | input | DATA_W | Offered outbound byte |
| tx_last | input | 1 | Offered byte ends the outbound frame |
| tx_ack | output | 1 | Offered byte fully shifted out; present the next |
| host_irq | output | 1 | Outbound frame pending |
| rx_data | output | DATA_W | Received frame body byte |
| rx_data_valid | output | 1 | `rx_data` holds a new body byte |
| frame_valid | output | 1 | Receive frame complete (one cycle) |
| frame_bytes | output | DATA_W | Body byte count of the completed frame |

## Verification
The receive path is tried with zero filler ahead of a frame, to show that filler is ignored while hunting. It is also tried with a length byte followed by body bytes whose patterns (alternating, nibble-split, single-bit) expose bit-order or alignment slips. A four-bit fragment of 0xF0 followed by NSS high separates a design that resets its bit counter from one that keeps a stale count. The mismatch would produce a misaligned non-zero length. Each clock mode carries a different receive frame and transmit frame at once, which separates edge selection errors and any coupling between the two directions. An outbound frame split across two NSS windows shows whether the interrupt drops too early and whether an interrupted byte is resent.

// File: rtl/sfp_pkg.sv
`timescale 1ns/1ps
package sfp_pkg;
    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_BODY = 1'b1
    } rx_state_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_PEND = 1'b1
    } tx_state_t;
endpackage

// File: rtl/sfp_sync_edge.sv
`timescale 1ns/1ps
module sfp_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic cpha,
    input  logic sck_in,
    input  logic nss_in,
    input  logic mosi_in,
    output logic active,
    output logic nss_fall,
    output logic sample,
    output logic shift,
    output logic mosi_bit
);
    // bit 2 = sck, bit 1 = nss, bit 0 = mosi
    logic [2:0] stage_q [SYNC_STAGES];
    logic       sck_prev_q;
    logic       active_prev_q;
    logic       lead_edge;
    logic       trail_edge;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= 3'b010;
                end else if (g == 0) begin
                    stage_q[g] <= {sck_in, nss_in, mosi_in};
                end else begin
                    stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q    <= 1'b0;
            active_prev_q <= 1'b0;
        end else begin
            sck_prev_q    <= stage_q[SYNC_STAGES-1][2];
            active_prev_q <= active;
        end
    end

    always_comb begin
        active     = !stage_q[SYNC_STAGES-1][1];
        mosi_bit   = stage_q[SYNC_STAGES-1][0];
        lead_edge  = (stage_q[SYNC_STAGES-1][2] != cpol) && (sck_prev_q == cpol);
        trail_edge = (stage_q[SYNC_STAGES-1][2] == cpol) && (sck_prev_q != cpol);
        nss_fall   = active && !active_prev_q;
        sample     = active && (cpha ? trail_edge : lead_edge);
        shift      = active && (cpha ? lead_edge : trail_edge);
    end
endmodule

// File: rtl/sfp_shifter.sv
`timescale 1ns/1ps
module sfp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic              active,
    input  logic              nss_fall,
    input  logic              sample,
    input  logic              shift,
    input  logic              mosi_bit,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              load_real,
    input  logic              load_last,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done_real,
    output logic              done_last,
    output logic              miso
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rxsr_q;
    logic [DATA_W-1:0] txsr_q;
    logic [DATA_W-1:0] rx_next;
    logic              loaded_q;
    logic              cur_real_q;
    logic              cur_last_q;
    logic              do_load;

    always_comb begin
        rx_next = {rxsr_q[DATA_W-2:0], mosi_bit};
        do_load = (nss_fall && !cpha) || (shift && !loaded_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rxsr_q     <= '0;
            txsr_q     <= '0;
            loaded_q   <= 1'b0;
            cur_real_q <= 1'b0;
            cur_last_q <= 1'b0;
            byte_done  <= 1'b0;
            rx_byte    <= '0;
            done_real  <= 1'b0;
            done_last  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                cnt_q    <= '0;
                txsr_q   <= '0;
                loaded_q <= 1'b0;
            end else begin
                if (do_load) begin
                    txsr_q     <= load_byte;
                    cur_real_q <= load_real;
                    cur_last_q <= load_last;
                    loaded_q   <= 1'b1;
                end else if (shift) begin
                    txsr_q <= {txsr_q[DATA_W-2:0], 1'b0};
                end
                if (sample) begin
                    rxsr_q <= rx_next;
                    if (cnt_q == LAST_BIT) begin
                        cnt_q     <= '0;
                        loaded_q  <= 1'b0;
                        byte_done <= 1'b1;
                        rx_byte   <= rx_next;
                        done_real <= cur_real_q;
                        done_last <= cur_last_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign miso = active & txsr_q[DATA_W-1];

    // R10
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !miso);

    // R3
    byte_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(active));
endmodule

// File: rtl/sfp_rx_fsm.sv
`timescale 1ns/1ps
module sfp_rx_fsm
    import sfp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_data_valid,
    output logic              frame_valid,
    output logic [DATA_W-1:0] frame_bytes
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    rx_state_t         state_q, state_d;
    logic [DATA_W-1:0] remain_q;
    logic [DATA_W-1:0] got_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: if (byte_done && (rx_byte != '0)) state_d = RX_BODY;
            RX_BODY: if (byte_done && (remain_q == ONE)) state_d = RX_HUNT;
            default: state_d = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q      <= '0;
            got_q         <= '0;
            rx_data       <= '0;
            rx_data_valid <= 1'b0;
            frame_valid   <= 1'b0;
            frame_bytes   <= '0;
        end else begin
            rx_data_valid <= 1'b0;
            frame_valid   <= 1'b0;
            if (byte_done) begin
                unique case (state_q)
                    RX_HUNT: begin
                        if (rx_byte != '0) begin
                            remain_q <= rx_byte;
                            got_q    <= '0;
                        end
                    end
                    RX_BODY: begin
                        rx_data       <= rx_byte;
                        rx_data_valid <= 1'b1;
                        got_q         <= got_q + 1'b1;
                        remain_q      <= remain_q - 1'b1;
                        if (remain_q == ONE) begin
                            frame_valid <= 1'b1;
                            frame_bytes <= got_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (rx_data_valid && (frame_bytes != '0)));

    // R5
    body_after_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_valid |-> $past(state_q == RX_BODY));
endmodule

// File: rtl/sfp_tx_fsm.sv
`timescale 1ns/1ps
module sfp_tx_fsm
    import sfp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic byte_done,
    input  logic done_real,
    input  logic done_last,
    output logic tx_ack,
    output logic host_irq
);
    tx_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (tx_valid) state_d = TX_PEND;
            TX_PEND: if (byte_done && done_real && done_last) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        host_irq = (state_q == TX_PEND);
        tx_ack   = byte_done && done_real;
    end

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_irq) |-> $past(tx_ack));

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(tx_valid));
endmodule

// File: rtl/spi_frame_port.sv
`timescale 1ns/1ps
module spi_frame_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_cpol,
    input  logic              strap_cpha,
    input  logic              spi_sck,
    input  logic              spi_nss,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_ack,
    output logic              host_irq,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_data_valid,
    output logic              frame_valid,
    output logic [DATA_W-1:0] frame_bytes
);
    logic              active, nss_fall, sample, shift, mosi_bit;
    logic              byte_done, done_real, done_last;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] load_byte;

    assign load_byte = tx_valid ? tx_data : '0;

    sfp_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .cpol(strap_cpol), .cpha(strap_cpha),
        .sck_in(spi_sck), .nss_in(spi_nss), .mosi_in(spi_mosi),
        .active(active), .nss_fall(nss_fall), .sample(sample),
        .shift(shift), .mosi_bit(mosi_bit)
    );

    sfp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cpha(strap_cpha), .active(active),
        .nss_fall(nss_fall), .sample(sample), .shift(shift),
        .mosi_bit(mosi_bit), .load_byte(load_byte), .load_real(tx_valid),
        .load_last(tx_last), .byte_done(byte_done), .rx_byte(rx_byte),
        .done_real(done_real), .done_last(done_last), .miso(spi_miso)
    );

    sfp_rx_fsm #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
        .rx_data(rx_data), .rx_data_valid(rx_data_valid),
        .frame_valid(frame_valid), .frame_bytes(frame_bytes)
    );

    sfp_tx_fsm u_tx (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .byte_done(byte_done),
        .done_real(done_real), .done_last(done_last),
        .tx_ack(tx_ack), .host_irq(host_irq)
    );

    // R8
    ack_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> host_irq);
endmodule

// File: tb/test_spi_frame_port.sv
`timescale 1ns/1ps
module test_spi_frame_port;
    localparam time HP = 160ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0;
    logic sck = 1'b0, nss = 1'b1, mosi = 1'b0;
    logic miso, tx_ack, host_irq, rx_data_valid, frame_valid;
    logic [7:0] rx_data, frame_bytes;

    logic [7:0] tx_q [0:15];
    int tx_n = 0, tx_i = 0, ack_n = 0;
    logic tx_valid, tx_last;
    logic [7:0] tx_data;
    assign tx_valid = (tx_i < tx_n);
    assign tx_data  = tx_valid ? tx_q[tx_i] : 8'h00;
    assign tx_last  = tx_valid && (tx_i == tx_n - 1);

    logic [7:0] mo_buf [0:15];
    logic [7:0] mi_buf [0:15];
    logic [7:0] rx_got [0:31];
    int rx_got_n = 0, fv_n = 0;
    logic [7:0] fv_bytes = 8'h00;

    int checks = 0, fails = 0;

    always #10ns clk = ~clk;

    spi_frame_port i_spi_frame_port (
        .clk(clk), .rst_n(rst_n), .strap_cpol(cpol), .strap_cpha(cpha),
        .spi_sck(sck), .spi_nss(nss), .spi_mosi(mosi), .spi_miso(miso),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ack(tx_ack), .host_irq(host_irq), .rx_data(rx_data),
        .rx_data_valid(rx_data_valid), .frame_valid(frame_valid),
        .frame_bytes(frame_bytes)
    );

    initial begin
        forever begin
            @(posedge clk);
            if (tx_ack) begin
                tx_i  <= tx_i + 1;
                ack_n <= ack_n + 1;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rx_data_valid && rx_got_n < 32) begin
                rx_got[rx_got_n] = rx_data;
                rx_got_n++;
            end
            if (frame_valid) begin
                fv_n++;
                fv_bytes = frame_bytes;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk);
        rx_got_n = 0; fv_n = 0; ack_n = 0;
    endtask

    task automatic set_mode(input logic p, input logic h);
        @(negedge clk);
        cpol = p; cpha = h; sck = p;
        repeat (8) @(negedge clk);
    endtask

    task automatic queue_tx(input int n);
        @(negedge clk);
        tx_i = 0; tx_n = n;
        repeat (4) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
        mi = 8'h00;
        for (int k = 0; k < nbits; k++) begin
            if (!cpha) begin
                mosi = mo[7-k];
                #(HP);
                mi = {mi[6:0], miso};
                sck = ~cpol;
                #(HP);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mo[7-k];
                #(HP);
                mi = {mi[6:0], miso};
                sck = cpol;
                #(HP);
            end
        end
    endtask

    task automatic xfer(input int n);
        @(negedge clk);
        nss = 1'b0;
        #(HP);
        for (int k = 0; k < n; k++) spi_bits(mo_buf[k], mi_buf[k], 8);
        #(HP);
        nss = 1'b1;
        #(4*HP);
    endtask

    task automatic t_reset();
        chk(miso == 1'b0, "R1 miso after reset", miso, 0);
        chk(host_irq == 1'b0, "R1 irq after reset", host_irq, 0);
        chk(!frame_valid && !rx_data_valid && !tx_ack, "R1 strobes after reset",
            {frame_valid, rx_data_valid, tx_ack}, 0);
    endtask

    task automatic t_idle();
        clr_mon();
        mo_buf[0] = 8'h00; mo_buf[1] = 8'h00;
        xfer(2);
        chk(mi_buf[0] == 8'h00 && mi_buf[1] == 8'h00, "R2 idle miso zeros",
            {mi_buf[0], mi_buf[1]}, 0);
        chk(rx_got_n == 0 && fv_n == 0, "R5 zero bytes ignored", rx_got_n + fv_n, 0);
        chk(miso == 1'b0, "R10 miso low with nss high", miso, 0);
    endtask

    task automatic t_rx_frame();
        clr_mon();
        mo_buf[0] = 8'h00; mo_buf[1] = 8'h03; mo_buf[2] = 8'hA5;
        mo_buf[3] = 8'h3C; mo_buf[4] = 8'h01;
        xfer(5);
        chk(fv_n == 1, "R5 one frame_valid", fv_n, 1);
        chk(fv_bytes == 8'd3, "R5 frame_bytes", fv_bytes, 3);
        chk(rx_got_n == 3, "R5 body byte count", rx_got_n, 3);
        chk(rx_got[0] == 8'hA5 && rx_got[1] == 8'h3C && rx_got[2] == 8'h01,
            "R3 msb-first body bytes", {rx_got[0], rx_got[1], rx_got[2]}, 24'hA53C01);
    endtask

    task automatic t_duplex(input logic p, input logic h, input logic [7:0] tb, input logic [7:0] rb);
        set_mode(p, h);
        clr_mon();
        tx_q[0] = 8'h02; tx_q[1] = tb; tx_q[2] = ~tb;
        queue_tx(3);
        mo_buf[0] = 8'h02; mo_buf[1] = rb; mo_buf[2] = {rb[3:0], rb[7:4]};
        xfer(3);
        chk(mi_buf[0] == 8'h02 && mi_buf[1] == tb && mi_buf[2] == ~tb,
            "R4 R9 tx bytes on miso", {mi_buf[0], mi_buf[1], mi_buf[2]},
            {8'h02, tb, ~tb});
        chk(fv_n == 1 && fv_bytes == 8'd2 && rx_got[0] == rb &&
            rx_got[1] == {rb[3:0], rb[7:4]}, "R4 R9 rx frame in duplex",
            {rx_got[0], rx_got[1]}, {rb, rb[3:0], rb[7:4]});
        chk(ack_n == 3 && host_irq == 1'b0, "R8 acks and irq release", ack_n, 3);
    endtask

    task automatic t_irq();
        set_mode(1'b0, 1'b0);
        clr_mon();
        tx_q[0] = 8'h02; tx_q[1] = 8'h11; tx_q[2] = 8'h22;
        queue_tx(3);
        chk(host_irq == 1'b1, "R7 irq raised when pending", host_irq, 1);
        mo_buf[0] = 8'h00; mo_buf[1] = 8'h00;
        xfer(2);
        chk(mi_buf[0] == 8'h02 && mi_buf[1] == 8'h11, "R8 first window bytes",
            {mi_buf[0], mi_buf[1]}, 16'h0211);
        chk(host_irq == 1'b1, "R7 irq held mid-frame", host_irq, 1);
        xfer(2);
        chk(mi_buf[0] == 8'h22, "R8 last byte resumes in next window", mi_buf[0], 8'h22);
        chk(mi_buf[1] == 8'h00, "R2 zeros after frame", mi_buf[1], 0);
        chk(host_irq == 1'b0, "R7 irq released after last byte", host_irq, 0);
    endtask

    task automatic t_partial();
        logic [7:0] junk;
        set_mode(1'b0, 1'b0);
        clr_mon();
        tx_q[0] = 8'h01; tx_q[1] = 8'h55;
        queue_tx(2);
        @(negedge clk);
        nss = 1'b0;
        #(HP);
        spi_bits(8'hF0, junk, 4);
        #(HP);
        nss = 1'b1;
        #(4*HP);
        chk(ack_n == 0 && host_irq == 1'b1, "R8 cut byte not acked", ack_n, 0);
        mo_buf[0] = 8'h01; mo_buf[1] = 8'h99;
        xfer(2);
        chk(mi_buf[0] == 8'h01 && mi_buf[1] == 8'h55, "R8 cut byte resent",
            {mi_buf[0], mi_buf[1]}, 16'h0155);
        chk(fv_n == 1 && fv_bytes == 8'd1 && rx_got[0] == 8'h99,
            "R6 partial byte discarded", {fv_bytes, rx_got[0]}, 16'h0199);
        chk(host_irq == 1'b0, "R7 irq released", host_irq, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_idle();
        t_rx_frame();
        t_duplex(1'b0, 1'b1, 8'h81, 8'hC3);
        t_duplex(1'b1, 1'b0, 8'h5A, 8'h18);
        t_duplex(1'b1, 1'b1, 8'hE4, 8'h6F);
        t_duplex(1'b0, 1'b0, 8'h3B, 8'h90);
        t_irq();
        t_partial();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule